// File: doc/BRIEF.md
# Queued SPI Master with Register Access

This block is a memory-mapped SPI master. Software writes bytes into a transmit queue through a data register. A control register holds a transaction-inhibit bit. While that bit is clear, the serial engine takes bytes from the queue one after another. It shifts each byte out on MOSI, most significant bit first, in SPI mode 0. At the same time it captures one byte from MISO into a receive queue, which software drains through a second data register. With the inhibit bit set, software can fill the queue first and then release it as one burst.

Each queue holds up to DEPTH bytes. DEPTH must be a power of two. Status, occupancy and slave-select registers complete the register set. A software-reset register acts only on one magic value. Two one-cycle event pulses and the two queue levels go to an interrupt block outside this one. Register reads return their data one cycle after the read strobe, with `bus_rvalid` high in that cycle. SCLK runs at the system clock divided by CLK_DIV, which must be even.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, `ss_n` is all ones, `sclk` is low, both levels are 0, and the status register reads 0x5.
- R2: A register read returns its data on `bus_rdata`, with `bus_rvalid` high, in the cycle after `bus_rd`. Unmapped addresses read 0.
- R3: A write to transmit data (0x68) queues bits 7:0 only. Each byte is sent MSB first. MOSI changes while SCLK is low and is stable at each SCLK rising edge. The SCLK period is CLK_DIV clocks, and SCLK idles low.
- R4: While control bit 8 is 1, no byte starts and written bytes accumulate. Clearing the bit sends all queued bytes in order.
- R5: Each transfer pushes the MISO byte, sampled on SCLK rising edges and MSB first, into the receive queue. A read of receive data (0x6C) pops bytes in arrival order, zero-extended.
- R6: A read of receive data with the receive queue empty returns 0xDEADBEEF and changes no queue.
- R7: A byte that completes while the receive queue is full is dropped, and `rx_overrun_evt` pulses for one cycle. Status bit 1 is 1 while the receive queue is full.
- R8: Status bit 3 is 1 while the transmit queue holds DEPTH bytes. A transmit-data write to a full queue is ignored.
- R9: A control write (0x60) with bit 5 set empties the transmit queue, and with bit 6 set empties the receive queue. Both bits read back 0. All other control bits are stored and read back.
- R10: Writes to the status register (0x64) have no effect. Status bits are: 0 receive empty, 1 receive full, 2 transmit empty, 3 transmit full.
- R11: Writing 0x0000000A to 0x40 clears control, sets slave select to all ones and empties both queues. Any other value written to 0x40 is ignored.
- R12: The slave-select register (0x70) resets to all ones and reads back as written. `ss_n[i]` equals register bit i.
- R13: The occupancy registers (0x74 transmit, 0x78 receive) read the byte count minus one, or 0 when the queue is empty.
- R14: `tx_empty_evt` pulses once when a byte finishes shifting and leaves the transmit queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low chip selects |
| tx_empty_evt | output | 1 | One-cycle pulse: transmit queue drained |
| rx_overrun_evt | output | 1 | One-cycle pulse: received byte dropped |
| tx_level | output | $clog2(DEPTH+1) | Bytes in the transmit queue |
| rx_level | output | $clog2(DEPTH+1) | Bytes in the receive queue |

## Verification
A wrong transmit read pointer or start condition shows up as a wrong byte on MOSI within one byte time, about 8 × CLK_DIV clocks. The serial slave model compares every byte against the order in which bytes were written. A receive-queue pointer or count fault shows up at the next read of receive data, occupancy or status, one cycle after the strobe. A fault in the full or empty boundaries shows up as a missing or extra overrun or transmit-empty pulse, so both pulses are counted against the expected totals. An inhibit or reset fault shows up as SCLK edges during a window in which none may occur, or as a nonzero level right after the clearing write.

// File: rtl/spi_fifo_master.sv
`timescale 1ns/1ps
module spi_fifo_master #(
  parameter int NUM_SS  = 1,
  parameter int CLK_DIV = 4,
  parameter int DEPTH   = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [7:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       bus_rvalid,
  output logic                       sclk,
  output logic                       mosi,
  input  logic                       miso,
  output logic [NUM_SS-1:0]          ss_n,
  output logic                       tx_empty_evt,
  output logic                       rx_overrun_evt,
  output logic [$clog2(DEPTH+1)-1:0] tx_level,
  output logic [$clog2(DEPTH+1)-1:0] rx_level
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [DW-1:0] DIV_END  = DW'(HALF - 1);

  localparam logic [7:0] A_SRST = 8'h40;
  localparam logic [7:0] A_CTRL = 8'h60;
  localparam logic [7:0] A_STAT = 8'h64;
  localparam logic [7:0] A_TXD  = 8'h68;
  localparam logic [7:0] A_RXD  = 8'h6C;
  localparam logic [7:0] A_SSEL = 8'h70;
  localparam logic [7:0] A_TXO  = 8'h74;
  localparam logic [7:0] A_RXO  = 8'h78;

  logic [31:0]   ctrl_q, ssel_q;
  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          busy;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_sh, rx_sh;

  wire soft_rst = bus_wr && bus_addr == A_SRST && bus_wdata == 32'h0000_000A;
  wire wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  wire wr_txd   = bus_wr && bus_addr == A_TXD;
  wire wr_ssel  = bus_wr && bus_addr == A_SSEL;
  wire rd_rxd   = bus_rd && bus_addr == A_RXD;

  wire tx_clr  = soft_rst || (wr_ctrl && bus_wdata[5]);
  wire rx_clr  = soft_rst || (wr_ctrl && bus_wdata[6]);
  wire tx_full = tx_cnt == FULL_CNT;
  wire rx_full = rx_cnt == FULL_CNT;
  wire tx_mt   = tx_cnt == '0;
  wire rx_mt   = rx_cnt == '0;

  wire start   = !busy && !ctrl_q[8] && !tx_mt && !tx_clr;
  wire fin     = busy && div_q == DIV_END && sclk && bit_q == 3'd7;
  wire tx_push = wr_txd && !tx_full;
  wire rx_pop  = rd_rxd && !rx_mt;
  wire rx_push = fin && (!rx_full || rx_pop);
  wire rx_drop = fin && rx_full && !rx_pop;

  function automatic logic [31:0] occ(input logic [CW-1:0] c);
    return (c == '0) ? 32'd0 : 32'(c - 1'b1);
  endfunction

  // transmit queue
  always_ff @(posedge clk) if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
    end
  end

  // receive queue
  always_ff @(posedge clk) if (rx_push) rx_mem[rx_wp] <= rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  // serial engine, mode 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk <= 1'b0; div_q <= '0; bit_q <= '0;
      tx_sh <= '0; rx_sh <= '0;
    end else if (soft_rst) begin
      busy <= 1'b0; sclk <= 1'b0; div_q <= '0; bit_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      sclk  <= 1'b0;
      div_q <= '0;
      bit_q <= '0;
      tx_sh <= tx_mem[tx_rp];
    end else if (busy) begin
      if (div_q == DIV_END) begin
        div_q <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_q == 3'd7) busy <= 1'b0;
          else begin
            bit_q <= bit_q + 1'b1;
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign mosi = busy & tx_sh[7];

  // control, select and events
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; ssel_q <= '1; tx_empty_evt <= 1'b0; rx_overrun_evt <= 1'b0;
    end else begin
      tx_empty_evt   <= fin && tx_mt && !tx_push && !soft_rst;
      rx_overrun_evt <= rx_drop && !soft_rst;
      if (soft_rst) begin
        ctrl_q <= '0; ssel_q <= '1;
      end else begin
        if (wr_ctrl) ctrl_q <= bus_wdata & ~32'h0000_0060;
        if (wr_ssel) ssel_q <= bus_wdata;
      end
    end
  end

  assign ss_n     = ssel_q[NUM_SS-1:0];
  assign tx_level = tx_cnt;
  assign rx_level = rx_cnt;

  // read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0; bus_rdata <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          A_CTRL:  bus_rdata <= ctrl_q;
          A_STAT:  bus_rdata <= {28'd0, tx_full, tx_mt, rx_full, rx_mt};
          A_RXD:   bus_rdata <= rx_mt ? 32'hDEAD_BEEF : {24'd0, rx_mem[rx_rp]};
          A_SSEL:  bus_rdata <= ssel_q;
          A_TXO:   bus_rdata <= occ(tx_cnt);
          A_RXO:   bus_rdata <= occ(rx_cnt);
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[8] && !busy) |=> !busy); // R4
  AST_EMPTY_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RXD && rx_mt) |=> (bus_rdata == 32'hDEAD_BEEF)); // R6
  AST_OVERRUN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun_evt |-> $past(rx_cnt) == FULL_CNT); // R7
  AST_TX_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !start && !tx_clr) |=> tx_full); // R8
  AST_ONESHOT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(bus_addr) == A_CTRL) |-> bus_rdata[6:5] == 2'b00); // R9
  AST_SRST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (&ss_n)); // R11
  AST_TXE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_evt |-> $past(tx_cnt) == '0); // R14
endmodule

// File: tb/spi_fifo_master_test.sv
`timescale 1ns/1ps
module spi_fifo_master_test;
  localparam int DEPTH = 256;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, sclk, mosi, miso;
  logic [0:0] ss_n;
  logic tx_empty_evt, rx_overrun_evt;
  logic [CW-1:0] tx_level, rx_level;

  always #2.5 clk = ~clk;

  spi_fifo_master #(.NUM_SS(1), .CLK_DIV(4), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .tx_empty_evt(tx_empty_evt), .rx_overrun_evt(rx_overrun_evt),
    .tx_level(tx_level), .rx_level(rx_level));

  int checks = 0, errors = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  int exp_ovr = 0, ovr_cnt = 0, txe_cnt = 0, rises = 0;
  int mo_n = 0, sl_idx = 0, rx_k = 0;
  logic [7:0] mo_sh = '0, sl_sh;
  bit per_bad = 0;
  realtime last_rise = 0;

  function automatic logic [7:0] slv_byte(input int k);
    return 8'(k * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial sl_sh = slv_byte(0);
  assign miso = sl_sh[7];

  // scoreboard monitor on the serial side
  always @(posedge sclk) if (rst_n) begin
    logic [7:0] e;
    if (mo_n != 0 && (($realtime - last_rise) > 20.1 || ($realtime - last_rise) < 19.9)) per_bad = 1;
    last_rise = $realtime;
    rises++;
    mo_sh = {mo_sh[6:0], mosi};
    mo_n++;
    if (mo_n == 8) begin
      mo_n = 0;
      if (exp_tx.size() == 0) chk(0, "R3 unexpected mosi byte", {24'd0, mo_sh}, 0);
      else begin
        e = exp_tx.pop_front();
        chk(mo_sh == e, "R3 mosi byte", {24'd0, mo_sh}, {24'd0, e});
      end
      chk(!per_bad, "R3 sclk period", {31'd0, per_bad}, 0);
      per_bad = 0;
      if (exp_rx.size() < DEPTH) exp_rx.push_back(slv_byte(rx_k));
      else exp_ovr++;
      rx_k++;
    end
  end

  always @(negedge sclk) if (rst_n) begin
    if (mo_n == 0) begin
      sl_idx++;
      sl_sh = slv_byte(sl_idx);
    end else sl_sh = {sl_sh[6:0], 1'b0};
  end

  always @(negedge clk) if (rst_n) begin
    if (tx_empty_evt) txe_cnt++;
    if (rx_overrun_evt) ovr_cnt++;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk(bus_rvalid, "R2 rvalid after read", {31'd0, bus_rvalid}, 1);
    d = bus_rdata;
  endtask

  task automatic push_tx(input logic [31:0] d);
    exp_tx.push_back(d[7:0]);
    wr(8'h68, d);
  endtask

  task automatic wait_idle();
    while (tx_level != 0) @(negedge clk);
    repeat (60) @(negedge clk);
  endtask

  task automatic pop_rx(input string tag);
    logic [31:0] d;
    logic [7:0] e;
    rd(8'h6C, d);
    e = exp_rx.pop_front();
    chk(d == {24'd0, e}, tag, d, {24'd0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ss_n == 1'b1, "R1 ss_n reset", {31'd0, ss_n}, 1);
    chk(sclk == 1'b0, "R1 sclk idle", {31'd0, sclk}, 0);
    chk(tx_level == 0 && rx_level == 0, "R1 levels", {23'd0, tx_level}, 0);
    rd(8'h64, d); chk(d == 32'h5, "R1 status reset", d, 32'h5);
    rd(8'h74, d); chk(d == 0, "R13 tx occupancy empty", d, 0);
    rd(8'h50, d); chk(d == 0, "R2 unmapped read", d, 0);

    // R3 R5 R14 single byte, upper bits dropped
    push_tx(32'h1234_56C3);
    wait_idle();
    chk(txe_cnt == 1, "R14 tx empty event single", txe_cnt, 1);
    rd(8'h78, d); chk(d == 0, "R13 rx occupancy one byte", d, 0);
    rd(8'h64, d); chk(d == 32'h4, "R10 status one rx byte", d, 32'h4);
    pop_rx("R5 rx byte single");

    // R4 inhibit then burst
    wr(8'h60, 32'h100);
    r0 = rises;
    push_tx(32'h81); push_tx(32'h7E); push_tx(32'h3C);
    repeat (200) @(negedge clk);
    chk(rises == r0, "R4 no sclk while inhibited", rises, r0);
    chk(tx_level == 3, "R4 bytes accumulate", {23'd0, tx_level}, 3);
    rd(8'h74, d); chk(d == 2, "R13 tx occupancy three", d, 2);
    wr(8'h60, 32'h0);
    wait_idle();
    chk(txe_cnt == 2, "R14 one event per burst", txe_cnt, 2);
    rd(8'h78, d); chk(d == 2, "R13 rx occupancy three", d, 2);
    pop_rx("R5 rx order 0"); pop_rx("R5 rx order 1"); pop_rx("R5 rx order 2");

    // R6 empty read
    rd(8'h6C, d); chk(d == 32'hDEAD_BEEF, "R6 empty marker", d, 32'hDEAD_BEEF);
    chk(rx_level == 0, "R6 no change on empty read", {23'd0, rx_level}, 0);

    // R9 control one-shot bits and queue resets
    wr(8'h60, 32'h1E0);
    rd(8'h60, d); chk(d == 32'h180, "R9 ctrl readback", d, 32'h180);
    wr(8'h68, 32'h11); wr(8'h68, 32'h22);
    r0 = rises;
    wr(8'h60, 32'h120);
    chk(tx_level == 0, "R9 tx queue reset", {23'd0, tx_level}, 0);
    wr(8'h60, 32'h0);
    repeat (100) @(negedge clk);
    chk(rises == r0, "R9 cleared bytes not sent", rises, r0);
    push_tx(32'h96);
    wait_idle();
    wr(8'h60, 32'h40);
    exp_rx.delete();
    chk(rx_level == 0, "R9 rx queue reset", {23'd0, rx_level}, 0);

    // R10 status write ignored
    wr(8'h64, 32'hF);
    rd(8'h64, d); chk(d == 32'h5, "R10 status write ignored", d, 32'h5);

    // R12 slave select, R11 soft reset
    wr(8'h70, 32'h0);
    chk(ss_n == 1'b0, "R12 ss_n low", {31'd0, ss_n}, 0);
    rd(8'h70, d); chk(d == 0, "R12 ss readback", d, 0);
    wr(8'h60, 32'h100);
    wr(8'h40, 32'h5);
    chk(ss_n == 1'b0, "R11 bad magic ignored ss", {31'd0, ss_n}, 0);
    rd(8'h60, d); chk(d == 32'h100, "R11 bad magic ignored ctrl", d, 32'h100);
    wr(8'h68, 32'h44); wr(8'h68, 32'h55);
    r0 = rises;
    wr(8'h40, 32'hA);
    chk(ss_n == 1'b1, "R11 soft reset ss", {31'd0, ss_n}, 1);
    chk(tx_level == 0, "R11 soft reset tx queue", {23'd0, tx_level}, 0);
    rd(8'h60, d); chk(d == 0, "R11 soft reset ctrl", d, 0);
    repeat (100) @(negedge clk);
    chk(rises == r0, "R11 flushed bytes not sent", rises, r0);

    // R8 transmit full, R7 receive full and overrun
    wr(8'h60, 32'h100);
    for (int i = 0; i < DEPTH; i++) push_tx(32'(i ^ 8'h5C));
    rd(8'h64, d); chk(d == 32'h9, "R8 tx full status", d, 32'h9);
    rd(8'h74, d); chk(d == DEPTH - 1, "R13 tx occupancy full", d, DEPTH - 1);
    wr(8'h68, 32'h77);
    chk(tx_level == DEPTH, "R8 write to full ignored", {23'd0, tx_level}, DEPTH);
    wr(8'h60, 32'h0);
    wait_idle();
    rd(8'h64, d); chk(d == 32'h6, "R7 rx full status", d, 32'h6);
    chk(ovr_cnt == 0, "R7 no overrun yet", ovr_cnt, 0);
    push_tx(32'h5A);
    wait_idle();
    chk(ovr_cnt == 1 && exp_ovr == 1, "R7 overrun event", ovr_cnt, 1);
    chk(rx_level == DEPTH, "R7 overrun byte dropped", {23'd0, rx_level}, DEPTH);
    chk(txe_cnt == 5, "R14 event total", txe_cnt, 5);
    for (int i = 0; i < DEPTH; i++) pop_rx("R5 rx drain order");
    rd(8'h64, d); chk(d == 32'h5, "R7 status after drain", d, 32'h5);
    chk(exp_tx.size() == 0, "R3 all bytes sent", exp_tx.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule